// File: doc/BRIEF.md
# Vectored Interrupt Controller with Stack Guard

This block collects interrupt requests for a small processor core from five sources: two active-low external pins, one comparator output and two timer overflow pulses. The pins and the comparator are watched for a falling edge. The timers deliver a one-cycle overflow pulse. Each event latches a pending flag. The flags live in two 8-bit control registers, beside one enable bit per source and a global master enable. The core can read and write both registers.

When the master enable is set and at least one source has both its flag and its enable set, the controller raises a call request. The request carries the vector address of the winning source. No request is raised while the core reports that its call stack is full. When the core acknowledges the request, the controller clears the serviced flag and the master enable, so interrupts do not nest unless software sets the master enable again. A wake output tells a halted core that an enabled source is pending.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After a synchronous reset both control registers read 0x00, and call_req and wake are low.
- R2: A 1-to-0 change on ext0_n, ext1_n or cmp_out sets its flag in the first clock edge at which the low level is seen, so it is readable one cycle later. The flags sit in ctl0 bit 4, bit 5 and bit 6. A 0-to-1 change has no effect.
- R3: A high level on tmr0_ovf or tmr1_ovf at a clock edge sets ctl1 bit 4 or ctl1 bit 5.
- R4: The vector addresses are 0x04 for ext0, 0x08 for ext1, 0x0C for cmp, 0x10 for timer 0 and 0x14 for timer 1.
- R5: call_req is high only when master enable (ctl0 bit 0) is set and some source has both its flag and its enable set.
- R6: While stack_full is high, call_req stays low. It rises again once stack_full falls, provided the request is still valid.
- R7: When several enabled sources are pending, call_vec carries the lowest vector address.
- R8: An edge with call_req and call_ack both high clears the flag of the served source and the master enable. All other flags keep their values.
- R9: While the master enable is clear, events still set their flags, and the flags stay set.
- R10: wake is high whenever some source has both its flag and its enable set, whatever the state of the master enable and stack_full.
- R11: If a hardware event on a flag bit falls in the same cycle as a register write or an acknowledge that would clear that bit, the bit ends up set.
- R12: The register layout is as follows. ctl0 bit 0 is master enable. ctl0 bits 1, 2 and 3 enable ext0, ext1 and cmp. ctl1 bits 1 and 2 enable timer 0 and timer 1. The flag bits can be written by software. ctl0 bit 7 and ctl1 bits 0, 3, 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext0_n | input | 1 | External interrupt pin 0, falling-edge triggered |
| ext1_n | input | 1 | External interrupt pin 1, falling-edge triggered |
| cmp_out | input | 1 | Comparator output, falling-edge triggered |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| stack_full | input | 1 | Call stack has no free entry |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 selects ctl0, 1 selects ctl1 |
| reg_wr_data | input | 8 | Write data |
| ctl0_q | output | 8 | Control register 0 readback |
| ctl1_q | output | 8 | Control register 1 readback |
| call_req | output | 1 | Vectored call request |
| call_vec | output | 8 | Target address of the request |
| call_ack | input | 1 | Core accepts the call |
| wake | output | 1 | An enabled source is pending |

## Verification
A single event with every enable off shows that flag latching is separate from request generation. A rising edge after that event shows that only falling edges count. Three sources fired in one cycle and then served one by one tell a priority bug apart from a flag that is cleared by mistake. Other patterns check that stack_full blocks a call until it falls, that a flag caught while the master enable is clear is served later, and that a write landing in the same cycle as an edge cannot lose that edge.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int NSRC   = 5;
    localparam int NEDGE  = 3;
    localparam int REG_W  = 8;
    localparam int VEC_W  = 8;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int VEC_STEP = 4;

    // bit positions inside the control registers
    localparam int MASTER_BIT = 0;
    localparam int EN_LO      = 1;
    localparam int FLAG_LO    = 4;
    localparam int R0_SRCS    = 3;   // sources 0..2 live in ctl0
    localparam int R1_SRCS    = NSRC - R0_SRCS;

    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_EXT1 = 3'd1,
        SRC_CMP  = 3'd2,
        SRC_TMR0 = 3'd3,
        SRC_TMR1 = 3'd4
    } src_e;

    typedef struct packed {
        logic            master;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] flag;
    } irq_state_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [VEC_W-1:0] vec;
    } irq_grant_t;

    // vector address grows with source index: 04,08,0C,10,14
    function automatic logic [VEC_W-1:0] src_vector(input logic [IDX_W-1:0] idx);
        return VEC_W'((int'(idx) + 1) * VEC_STEP);
    endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig_in,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev;

    // the previous value is tracked even in reset so no false edge appears
    always_ff @(posedge clk) begin
        prev <= sig_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign fall[i] = prev[i] & ~sig_in[i];

        a_r2_fall_needs_low: assert property (@(posedge clk) disable iff (rst)
            fall[i] |-> !sig_in[i]);
        a_r2_fell_detected: assert property (@(posedge clk) disable iff (rst)
            $fell(sig_in[i]) |-> fall[i]);
    end

endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
    import irq_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  hw_set,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ack_fire,
    input  logic [IDX_W-1:0] ack_idx,
    output irq_state_t       st
);
    irq_state_t nxt;

    always_comb begin
        nxt = st;
        // lowest priority: software write
        if (wr_en) begin
            if (!wr_sel) begin
                nxt.master = wr_data[MASTER_BIT];
                for (int i = 0; i < R0_SRCS; i++) begin
                    nxt.en[i]   = wr_data[EN_LO + i];
                    nxt.flag[i] = wr_data[FLAG_LO + i];
                end
            end else begin
                for (int i = 0; i < R1_SRCS; i++) begin
                    nxt.en[R0_SRCS + i]   = wr_data[EN_LO + i];
                    nxt.flag[R0_SRCS + i] = wr_data[FLAG_LO + i];
                end
            end
        end
        // acknowledge overrides the write
        if (ack_fire) begin
            nxt.master        = 1'b0;
            nxt.flag[ack_idx] = 1'b0;
        end
        // hardware events override everything
        nxt.flag = nxt.flag | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        a_r11_hw_set_wins: assert property (@(posedge clk) disable iff (rst)
            hw_set[i] |=> st.flag[i]);
    end

    a_r8_master_cleared: assert property (@(posedge clk) disable iff (rst)
        ack_fire |=> !st.master);
    a_r8_flag_cleared: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && !hw_set[ack_idx]) |=> !st.flag[$past(ack_idx)]);
    a_r9_flags_stick: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !ack_fire) |=> ((st.flag & $past(st.flag)) == $past(st.flag)));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  irq_state_t st,
    input  logic       stack_full,
    output irq_grant_t grant,
    output logic       wake
);
    logic [NSRC-1:0]  req;
    logic [IDX_W-1:0] pick;

    assign req = st.flag & st.en;

    // scan downward so the lowest index is left standing
    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) pick = IDX_W'(i);
        end
    end

    assign grant.valid = st.master & (|req) & ~stack_full;
    assign grant.idx   = pick;
    assign grant.vec   = src_vector(pick);
    assign wake        = |req;

    a_r6_full_blocks: assert property (@(posedge clk) disable iff (rst)
        stack_full |-> !grant.valid);
    a_r5_master_gate: assert property (@(posedge clk) disable iff (rst)
        !st.master |-> !grant.valid);
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        grant.valid |-> (req[grant.idx] &&
                         ((req & ((NSRC'(1) << grant.idx) - NSRC'(1))) == '0)));
    a_r10_wake_on_grant: assert property (@(posedge clk) disable iff (rst)
        grant.valid |-> wake);

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irq_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ext0_n,
    input  logic             ext1_n,
    input  logic             cmp_out,
    input  logic             tmr0_ovf,
    input  logic             tmr1_ovf,
    input  logic             stack_full,
    input  logic             reg_wr_en,
    input  logic             reg_wr_sel,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] ctl0_q,
    output logic [REG_W-1:0] ctl1_q,
    output logic             call_req,
    output logic [VEC_W-1:0] call_vec,
    input  logic             call_ack,
    output logic             wake
);
    logic [NEDGE-1:0] edge_in;
    logic [NEDGE-1:0] edge_fall;
    logic [NSRC-1:0]  hw_set;
    irq_state_t       st;
    irq_grant_t       grant;
    logic             ack_fire;

    assign edge_in = {cmp_out, ext1_n, ext0_n};

    irq_edge_det #(.N(NEDGE)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_in (edge_in),
        .fall   (edge_fall)
    );

    assign hw_set   = {tmr1_ovf, tmr0_ovf, edge_fall};
    assign ack_fire = call_ack & grant.valid;

    irq_flag_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .hw_set   (hw_set),
        .wr_en    (reg_wr_en),
        .wr_sel   (reg_wr_sel),
        .wr_data  (reg_wr_data),
        .ack_fire (ack_fire),
        .ack_idx  (grant.idx),
        .st       (st)
    );

    irq_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .st         (st),
        .stack_full (stack_full),
        .grant      (grant),
        .wake       (wake)
    );

    // register readback packing
    always_comb begin
        ctl0_q = '0;
        ctl1_q = '0;
        ctl0_q[MASTER_BIT] = st.master;
        for (int i = 0; i < R0_SRCS; i++) begin
            ctl0_q[EN_LO + i]   = st.en[i];
            ctl0_q[FLAG_LO + i] = st.flag[i];
        end
        for (int i = 0; i < R1_SRCS; i++) begin
            ctl1_q[EN_LO + i]   = st.en[R0_SRCS + i];
            ctl1_q[FLAG_LO + i] = st.flag[R0_SRCS + i];
        end
    end

    assign call_req = grant.valid;
    assign call_vec = grant.vec;

    a_r4_legal_vector: assert property (@(posedge clk) disable iff (rst)
        call_req |-> (call_vec inside {8'h04, 8'h08, 8'h0C, 8'h10, 8'h14}));
    a_r8_no_nesting: assert property (@(posedge clk) disable iff (rst)
        (call_req && call_ack) |=> !call_req);
    a_r12_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (ctl0_q[7] == 1'b0) && ((ctl1_q & 8'hC9) == 8'h00));

endmodule

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext0_n = 1'b1, ext1_n = 1'b1, cmp_out = 1'b1;
    logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0;
    logic       stack_full = 1'b0;
    logic       reg_wr_en = 1'b0, reg_wr_sel = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [7:0] ctl0_q, ctl1_q, call_vec;
    logic       call_req, wake;
    logic       call_ack = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_q[$];
    logic       ack_allow = 1'b0;
    logic       done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    vec_irq_ctrl u0 (
        .clk(clk), .rst(rst), .ext0_n(ext0_n), .ext1_n(ext1_n), .cmp_out(cmp_out),
        .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .stack_full(stack_full),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .ctl0_q(ctl0_q), .ctl1_q(ctl1_q), .call_req(call_req), .call_vec(call_vec),
        .call_ack(call_ack), .wake(wake)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // driver side of the scoreboard
    task automatic expect_call(input logic [7:0] v);
        exp_q.push_back(v);
        ack_allow = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        ack_allow = 1'b0;
    endtask

    // monitor: accepts calls and compares them against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (call_ack) begin
                call_ack = 1'b0;
            end else if (ack_allow && call_req) begin
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected call", call_vec, 8'hFF);
                end else begin
                    chk("R4/R7 call vector", call_vec, exp_q.pop_front());
                end
                call_ack = 1'b1;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctl0", ctl0_q, 8'h00);
        chk("R1 ctl1", ctl1_q, 8'h00);
        chk("R1 call_req/wake", {6'b0, call_req, wake}, 8'h00);

        // R12 layout and unused bits
        wr(1'b0, 8'hFF);
        chk("R12 ctl0 write", ctl0_q, 8'h7F);
        wr(1'b1, 8'hFF);
        chk("R12 ctl1 write", ctl1_q, 8'h36);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);
        chk("R12 clear", ctl0_q | ctl1_q, 8'h00);

        // R2 falling edge with all enables off
        @(negedge clk); ext0_n = 1'b0;
        @(negedge clk);
        chk("R2 ext0 flag", ctl0_q, 8'h10);
        chk("R5 no call when disabled", {7'b0, call_req}, 8'h00);
        chk("R10 no wake when disabled", {7'b0, wake}, 8'h00);
        ext0_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 rising ignored", ctl0_q, 8'h10);
        wr(1'b0, 8'h00);

        // R9 flag latched while masked, served later
        wr(1'b0, 8'h04);
        @(negedge clk); ext1_n = 1'b0;
        @(negedge clk);
        chk("R9 ext1 pending masked", ctl0_q, 8'h24);
        chk("R9 no call masked", {7'b0, call_req}, 8'h00);
        chk("R10 wake while masked", {7'b0, wake}, 8'h01);
        ext1_n = 1'b1;
        wr(1'b0, 8'h25);
        chk("R5 call raised", {7'b0, call_req}, 8'h01);
        expect_call(8'h08);
        chk("R8 flag and master cleared", ctl0_q, 8'h04);

        // R7 priority, R3 timers, R8 others kept
        wr(1'b1, 8'h06);
        wr(1'b0, 8'h0F);
        @(negedge clk); cmp_out = 1'b0; tmr0_ovf = 1'b1; tmr1_ovf = 1'b1;
        @(negedge clk); tmr0_ovf = 1'b0; tmr1_ovf = 1'b0;
        chk("R2 cmp flag", ctl0_q, 8'h4F);
        chk("R3 timer flags", ctl1_q, 8'h36);
        chk("R7 lowest first", call_vec, 8'h0C);
        expect_call(8'h0C);
        chk("R8 ctl0 after cmp", ctl0_q, 8'h0E);
        chk("R8 timer flags kept", ctl1_q, 8'h36);
        wr(1'b0, 8'h0F);
        expect_call(8'h10);
        chk("R8 tmr0 cleared", ctl1_q, 8'h26);
        wr(1'b0, 8'h0F);
        expect_call(8'h14);
        chk("R8 tmr1 cleared", ctl1_q, 8'h06);
        wr(1'b0, 8'h0F);
        chk("R5 nothing pending", {7'b0, call_req}, 8'h00);
        cmp_out = 1'b1;

        // R6 stack full blocks
        @(negedge clk); stack_full = 1'b1; ext0_n = 1'b0;
        @(negedge clk);
        chk("R6 ctl0 pending", ctl0_q, 8'h1F);
        chk("R6 blocked when full", {7'b0, call_req}, 8'h00);
        chk("R10 wake when full", {7'b0, wake}, 8'h01);
        ext0_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 still blocked", {7'b0, call_req}, 8'h00);
        stack_full = 1'b0;
        #1;
        chk("R6 released", {7'b0, call_req}, 8'h01);
        expect_call(8'h04);
        chk("R6 served", ctl0_q, 8'h0E);

        // R11 hardware event beats a simultaneous write
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = 1'b0; reg_wr_data = 8'h00; ext1_n = 1'b0;
        @(negedge clk);
        reg_wr_en = 1'b0;
        chk("R11 hw set wins", ctl0_q, 8'h20);
        ext1_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule